// File: doc/BRIEF.md
# Configurable Programmable Logic Array

This block is a sum-of-products logic array whose whole personality is set at run time. A bank of product terms reads the inputs, and any product term may include the true and the inverted form of every input. A bank of sum gates follows, and any sum may take any product term, so one product term can feed several outputs. Each sum then passes through a per-output invert/pass stage. After that, a per-output choice picks either a clocked copy of the value or the value itself.

The personality is held in one serial configuration chain. It is filled one bit per clock while the configuration enable is high, and all outputs are held at zero during that time. A synchronous reset clears the output flip-flops only. The chain has `2*N_IN*N_TERM + N_OUT*N_TERM + 2*N_OUT` bits, which is 104 with the default N_IN=4, N_TERM=8, N_OUT=4.

Top module: `cfg_pla`

## Requirements
- R1: With `rst` high at a rising edge, every output flip-flop clears to 0, so an output in registered mode reads 0 after that edge, whatever the inputs are.
- R2: Literal connection bit `t*2*N_IN + 2*i` puts input i (true) into product term t. Bit `t*2*N_IN + 2*i + 1` puts the inverted input i into term t. A term is the AND of its connected literals.
- R3: A product term with no literal connected evaluates to 1. A term connected to both forms of the same input evaluates to 0.
- R4: Bit `2*N_IN*N_TERM + o*N_TERM + t` connects term t to sum o. One term may feed several sums. A sum with no term connected is 0.
- R5: Invert bit `2*N_IN*N_TERM + N_OUT*N_TERM + o` set to 1 complements sum o. Set to 0, the sum passes unchanged.
- R6: Mode bit `2*N_IN*N_TERM + N_OUT*N_TERM + N_OUT + o` set to 1 makes output o take the polarity-stage value at each rising edge, with one edge of latency. Set to 0, the output follows that value combinationally.
- R7: While `cfg_en` is high, the chain takes one bit of `cfg_din` per rising edge. After a full load, the k-th bit shifted in controls chain position k, in the layout given by R2, R4, R5 and R6.
- R8: While `cfg_en` is high, `data_out` is all zero.
- R9: With X, Y, Z on inputs 0, 1, 2 and terms XY, XZ', XY', YZ, the array gives A = XY + XZ' and B = XY' + YZ + XZ', with XZ' shared by both.
- R10: A fixed assignment of terms to sums (output o owns terms 2o and 2o+1) is reproduced by programming that pattern into the sum connections.
- R11: For any configuration, every output equals a behavioural sum-of-products model over all input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and the output flip-flops |
| rst | input | 1 | Synchronous reset of the output flip-flops |
| cfg_en | input | 1 | Configuration mode: the chain shifts and outputs are forced to 0 |
| cfg_din | input | 1 | Serial configuration bit |
| data_in | input | N_IN | Array inputs |
| data_out | output | N_OUT | Array outputs |

## Verification
The shared-term setting is swept over all sixteen input values and compared against the two closed-form equations. This shows whether a shared term reaches both sums and whether true and inverted literals are routed correctly. The same setting is repeated with all outputs inverted and with all outputs registered, which separates the polarity stage and the flip-flop latency from the planes. A directed latency step changes the inputs between edges, so a combinational output and a registered output must differ for one cycle. Empty terms, conflicting literals, empty sums, a fixed term pattern and twelve random personalities against a behavioural model cover the remaining cases of the configuration layout.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
  // Number of literals a product term can see.
  function automatic int lit_count(input int n_in);
    return 2 * n_in;
  endfunction

  // Total length of the serial configuration chain.
  function automatic int chain_len(input int n_in, input int n_term, input int n_out);
    return lit_count(n_in) * n_term + n_out * n_term + 2 * n_out;
  endfunction

  // Chain offsets of each configuration field.
  function automatic int or_base(input int n_in, input int n_term);
    return lit_count(n_in) * n_term;
  endfunction

  function automatic int inv_base(input int n_in, input int n_term, input int n_out);
    return or_base(n_in, n_term) + n_out * n_term;
  endfunction

  function automatic int sel_base(input int n_in, input int n_term, input int n_out);
    return inv_base(n_in, n_term, n_out) + n_out;
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
`timescale 1ns/1ps
module pla_cfg_chain #(
  parameter int LEN = 104
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_en,
  input  logic           cfg_din,
  output logic [LEN-1:0] cfg_q
);
  // New bits enter at the top and move toward bit 0, so after LEN shifts
  // the first bit shifted in sits at position 0.
  always_ff @(posedge clk) begin
    if (cfg_en) cfg_q <= {cfg_din, cfg_q[LEN-1:1]};
  end

  // R7: the newest chain bit is the serial input of the previous edge
  p_shift_in_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_q[LEN-1] == $past(cfg_din));

  // R7: the chain holds its content outside configuration mode
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_IN-1:0]               data_in,
  input  logic [N_TERM*2*N_IN-1:0]      and_cfg,
  output logic [N_TERM-1:0]             terms
);
  localparam int LITS = pla_pkg::lit_count(N_IN);

  // Literal vector: even slot true input, odd slot inverted input.
  function automatic logic [LITS-1:0] make_lits(input logic [N_IN-1:0] x);
    logic [LITS-1:0] l;
    for (int i = 0; i < N_IN; i++) begin
      l[2*i]   = x[i];
      l[2*i+1] = ~x[i];
    end
    return l;
  endfunction

  // A term fails only on a connected literal that is 0.
  function automatic logic eval_term(input logic [LITS-1:0] conn, input logic [LITS-1:0] l);
    return &(~conn | l);
  endfunction

  logic [LITS-1:0] lits;
  assign lits = make_lits(data_in);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LITS-1:0] conn;
    assign conn     = and_cfg[t*LITS +: LITS];
    assign terms[t] = eval_term(conn, lits);

    // R3: a term with no literal is constant 1
    p_empty_term_r3: assert property (@(posedge clk) disable iff (rst)
      (conn == '0) |-> terms[t]);

    for (genvar i = 0; i < N_IN; i++) begin : g_conflict
      // R3: both forms of one input force the term to 0
      p_conflict_r3: assert property (@(posedge clk) disable iff (rst)
        (conn[2*i] && conn[2*i+1]) |-> !terms[t]);
      // R2: a connected true literal at 0 kills the term
      p_true_lit_r2: assert property (@(posedge clk) disable iff (rst)
        (conn[2*i] && !data_in[i]) |-> !terms[t]);
    end
  end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_TERM-1:0]         terms,
  input  logic [N_OUT*N_TERM-1:0]   or_cfg,
  output logic [N_OUT-1:0]          sums
);
  function automatic logic eval_sum(input logic [N_TERM-1:0] conn, input logic [N_TERM-1:0] tv);
    return |(conn & tv);
  endfunction

  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    logic [N_TERM-1:0] conn;
    assign conn    = or_cfg[o*N_TERM +: N_TERM];
    assign sums[o] = eval_sum(conn, terms);

    // R4: a sum with no term connected is 0
    p_empty_sum_r4: assert property (@(posedge clk) disable iff (rst)
      (conn == '0) |-> !sums[o]);
    // R4: a sum is 1 exactly when some connected term is 1
    p_any_term_r4: assert property (@(posedge clk) disable iff (rst)
      ((conn & terms) != '0) |-> sums[o]);
  end
endmodule

// File: rtl/pla_out_stage.sv
`timescale 1ns/1ps
module pla_out_stage #(
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic [N_OUT-1:0] sums,
  input  logic [N_OUT-1:0] inv_cfg,
  input  logic [N_OUT-1:0] sel_cfg,
  output logic [N_OUT-1:0] data_out
);
  logic [N_OUT-1:0] pol_val;
  logic [N_OUT-1:0] reg_q;

  assign pol_val = sums ^ inv_cfg;

  // Flip-flops clear under reset and during configuration.
  always_ff @(posedge clk) begin
    if (rst || cfg_en) reg_q <= '0;
    else               reg_q <= pol_val;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign data_out[o] = cfg_en ? 1'b0 : (sel_cfg[o] ? reg_q[o] : pol_val[o]);

    // R6: a registered output shows the polarity value of the previous edge
    p_reg_latency_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!cfg_en) && !cfg_en && sel_cfg[o] && $past(sel_cfg[o]))
        |-> data_out[o] == $past(pol_val[o]));
    // R5: invert bit complements the sum at a combinational output
    p_polarity_r5: assert property (@(posedge clk) disable iff (rst)
      (!cfg_en && !sel_cfg[o]) |-> data_out[o] == (sums[o] ^ inv_cfg[o]));
  end

  // R1: reset clears every registered output at the next edge
  p_reset_clear_r1: assert property (@(posedge clk)
    ($past(rst) && !cfg_en) |-> ((data_out & sel_cfg) == '0));
  // R8: configuration mode forces all outputs to 0
  p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> data_out == '0);
endmodule

// File: rtl/cfg_pla.sv
`timescale 1ns/1ps
module cfg_pla #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_OUT-1:0] data_out
);
  localparam int LEN      = pla_pkg::chain_len(N_IN, N_TERM, N_OUT);
  localparam int AND_BITS = pla_pkg::or_base(N_IN, N_TERM);
  localparam int OR_BASE  = pla_pkg::or_base(N_IN, N_TERM);
  localparam int INV_BASE = pla_pkg::inv_base(N_IN, N_TERM, N_OUT);
  localparam int SEL_BASE = pla_pkg::sel_base(N_IN, N_TERM, N_OUT);

  logic [LEN-1:0]          cfg_q;
  logic [N_TERM-1:0]       terms;
  logic [N_OUT-1:0]        sums;
  logic [AND_BITS-1:0]     and_cfg;
  logic [N_OUT*N_TERM-1:0] or_cfg;
  logic [N_OUT-1:0]        inv_cfg;
  logic [N_OUT-1:0]        sel_cfg;

  assign and_cfg = cfg_q[0 +: AND_BITS];
  assign or_cfg  = cfg_q[OR_BASE +: N_OUT*N_TERM];
  assign inv_cfg = cfg_q[INV_BASE +: N_OUT];
  assign sel_cfg = cfg_q[SEL_BASE +: N_OUT];

  pla_cfg_chain #(.LEN(LEN)) u_chain (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_q(cfg_q)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk(clk), .rst(rst), .data_in(data_in), .and_cfg(and_cfg), .terms(terms)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk(clk), .rst(rst), .terms(terms), .or_cfg(or_cfg), .sums(sums)
  );

  pla_out_stage #(.N_OUT(N_OUT)) u_out (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .sums(sums),
    .inv_cfg(inv_cfg), .sel_cfg(sel_cfg), .data_out(data_out)
  );
endmodule

// File: tb/cfg_pla_tb.sv
`timescale 1ns/1ps
module cfg_pla_tb;
  localparam int NI = 4, NT = 8, NO = 4;
  localparam int L    = 104;          // 8*8 + 4*8 + 4 + 4
  localparam int ORB  = 64;
  localparam int INVB = 96;
  localparam int SELB = 100;

  logic clk = 1'b0, rst = 1'b1, cfg_en = 1'b0, cfg_din = 1'b0;
  logic [NI-1:0] data_in = '0;
  logic [NO-1:0] data_out;
  logic [L-1:0]  cfgv;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_pla #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .data_in(data_in), .data_out(data_out)
  );

  task automatic chk(input string tag, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Behavioural model, written from the bit layout of R2, R4, R5.
  function automatic logic [NO-1:0] model(input logic [L-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] tv;
    logic [NO-1:0] r;
    for (int t = 0; t < NT; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[t*8 + 2*i]     && !x[i]) tv[t] = 1'b0;
        if (c[t*8 + 2*i + 1] &&  x[i]) tv[t] = 1'b0;
      end
    end
    for (int o = 0; o < NO; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < NT; t++) if (c[ORB + o*8 + t] && tv[t]) r[o] = 1'b1;
      r[o] = r[o] ^ c[INVB + o];
    end
    return r;
  endfunction

  function automatic void lit(input int t, input int i, input bit neg);
    cfgv[t*8 + 2*i + (neg ? 1 : 0)] = 1'b1;
  endfunction

  function automatic void con(input int o, input int t);
    cfgv[ORB + o*8 + t] = 1'b1;
  endfunction

  // R7/R8: shift cfgv in, bit 0 first; check outputs are quiet mid-load.
  task automatic load();
    @(negedge clk);
    cfg_en = 1'b1;
    for (int k = 0; k < L; k++) begin
      cfg_din = cfgv[k];
      @(negedge clk);
      if (k == L/2) chk("R8 quiet during load", data_out, '0);
    end
    chk("R8 quiet at end of load", data_out, '0);
    cfg_en = 1'b0;
  endtask

  // Apply x, let one edge pass, sample: both modes settle to the model.
  task automatic apply(input logic [NI-1:0] x);
    @(negedge clk);
    data_in = x;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [NO-1:0] shared_exp(input logic [NI-1:0] x);
    logic X, Y, Z;
    X = x[0]; Y = x[1]; Z = x[2];
    return {1'b0, 1'b1, (X & ~Y) | (Y & Z) | (X & ~Z), (X & Y) | (X & ~Z)};
  endfunction

  task automatic build_shared();
    cfgv = '0;
    lit(0, 0, 0); lit(0, 1, 0);        // XY
    lit(1, 0, 0); lit(1, 2, 1);        // XZ'
    lit(2, 0, 0); lit(2, 1, 1);        // XY'
    lit(3, 1, 0); lit(3, 2, 0);        // YZ
    lit(5, 3, 0); lit(5, 3, 1);        // conflicting term
    con(0, 0); con(0, 1);
    con(1, 2); con(1, 3); con(1, 1);
    con(2, 4);                          // empty term
    con(3, 5);
  endtask

  task automatic t_reset_state();
    build_shared();
    cfgv[SELB +: 4] = 4'b1111;
    load();                             // rst still high
    data_in = 4'b0011;
    @(posedge clk); #1;
    chk("R1 reset state registered outputs", data_out, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset release", data_out, shared_exp(4'b0011));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 sync reset clears", data_out, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_shared();
    build_shared();
    load();
    for (int v = 0; v < 16; v++) begin
      apply(v[3:0]);
      chk($sformatf("R9 R2 R3 shared x=%0d", v), data_out, shared_exp(v[3:0]));
    end
  endtask

  task automatic t_invert();
    build_shared();
    cfgv[INVB +: 4] = 4'b1111;
    load();
    for (int v = 0; v < 16; v += 3) begin
      apply(v[3:0]);
      chk($sformatf("R5 inverted x=%0d", v), data_out, ~shared_exp(v[3:0]));
    end
  endtask

  task automatic t_registered();
    build_shared();
    cfgv[SELB +: 4] = 4'b1111;
    load();
    for (int v = 0; v < 16; v += 5) begin
      apply(v[3:0]);
      chk($sformatf("R6 registered x=%0d", v), data_out, shared_exp(v[3:0]));
    end
  endtask

  task automatic t_latency();
    cfgv = '0;
    lit(0, 0, 0);
    con(0, 0); con(1, 0);
    cfgv[SELB + 0] = 1'b1;              // out0 registered, out1 direct
    load();
    apply(4'b0000);
    chk("R6 latency base", data_out, 4'b0000);
    @(negedge clk);
    data_in = 4'b0001;
    #1;
    chk("R6 direct follows, registered holds", data_out, 4'b0010);
    @(posedge clk); #1;
    chk("R6 registered after edge", data_out, 4'b0011);
  endtask

  task automatic t_empty_sum();
    cfgv = '0;
    cfgv[INVB +: 4] = 4'b0101;
    load();
    apply(4'b1111);
    chk("R4 R5 empty sums x=15", data_out, 4'b0101);
    apply(4'b0000);
    chk("R4 R5 empty sums x=0", data_out, 4'b0101);
  endtask

  task automatic t_pal();
    cfgv = '0;
    for (int k = 0; k < ORB; k++) cfgv[k] = (($urandom % 4) == 0);
    for (int o = 0; o < NO; o++) begin con(o, 2*o); con(o, 2*o + 1); end
    load();
    for (int v = 0; v < 16; v++) begin
      apply(v[3:0]);
      chk($sformatf("R10 fixed pattern x=%0d", v), data_out, model(cfgv, v[3:0]));
    end
  endtask

  task automatic t_random();
    for (int r = 0; r < 12; r++) begin
      for (int k = 0; k < ORB; k++) cfgv[k] = (($urandom % 4) == 0);
      for (int k = ORB; k < L; k++) cfgv[k] = (($urandom % 2) == 0);
      load();
      for (int v = 0; v < 16; v++) begin
        apply(v[3:0]);
        chk($sformatf("R11 R7 random cfg %0d x=%0d", r, v), data_out, model(cfgv, v[3:0]));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    t_shared();
    t_invert();
    t_registered();
    t_latency();
    t_empty_sum();
    t_pal();
    t_random();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule